// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps large, naturally aligned regions of the effective address space onto physical memory using a small bank of translation register pairs. There are two sides, one for instruction fetches and one for data accesses. Each side has a set of entries. Each entry is an upper register and a lower register. The upper register gives the effective block index, a block-length mask and two validity bits, one per privilege level. The lower register gives the physical block index, four storage-attribute bits and a two-bit protection code. Software programs the pairs through a simple register port with combinational read-back.

A lookup presents a 32-bit effective address, a side select, a privilege bit and an access type. One clock later the unit returns four things: a hit flag, the translated physical address, the storage attributes of the entry that hit, and a protection-fault flag. The block-length mask is a run of ones filled from the low end. Each mask bit removes one more effective-address bit from the compare and lets that bit pass through to the physical address. This lets one entry cover anything from 128 KB to 256 MB.

Top module: `bat_xlate`

## Requirements
- R1: After reset every register of every pair reads zero, and no lookup hits until an entry is programmed.
- R2: The config address is {side (1 = data), entry index [2:1], half (0 = upper, 1 = lower)}. A write stores the word and a read returns it in the same cycle. Upper bits 16:13 always read zero. Lower bits 16:7 and bit 2 always read zero.
- R3: In instruction-side lower registers the guarded bit (bit 3) is stored as zero whatever is written. Data-side lower registers keep it.
- R4: An entry can hit in supervisor mode only when upper bit 1 is set, and in user mode only when upper bit 0 is set.
- R5: An entry hits when effective address bits 31:17 equal upper bits 31:17, ignoring the positions covered by the mask. The mask is held in upper bits 12:2, and mask bit k covers address bit 17+k. A zero mask gives a 128 KB block.
- R6: The physical address is built from three parts. Bits 31:17 are lower bits 31:17 OR the effective-address bits covered by the mask. Bits 16:0 are copied from the effective address.
- R7: An instruction lookup searches only instruction-side entries. A data lookup searches only data-side entries.
- R8: When several entries of the searched side hit, the lowest-numbered one supplies the result.
- R9: The attribute output is {write-through, cache-inhibit, coherent, guarded}, taken from lower bits 6:3 of the winning entry. On a miss it is zero, and so is the physical address.
- R10: The protection code sits in lower bits 1:0. Code 00 faults on any access. Codes 01 and 11 fault on a write. Code 10 never faults. A miss never faults.
- R11: The response is registered. The result of a request sampled at one clock edge appears after that edge, with the valid output set. In a cycle with no request, all response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select {side, index, half} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| lk_req | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address |
| lk_is_data | input | 1 | 1 = data side, 0 = instruction side |
| lk_super | input | 1 | 1 = supervisor, 0 = user |
| lk_write | input | 1 | 1 = store access |
| rsp_vld | output | 1 | Response valid |
| rsp_hit | output | 1 | An entry matched |
| rsp_pa | output | 32 | Physical address |
| rsp_attr | output | 4 | {write-through, cache-inhibit, coherent, guarded} |
| rsp_fault | output | 1 | Protection violation |

## Verification
The bound checker watches the response framing on every cycle. It checks that a valid response follows each request and that idle cycles stay zero. It also checks that faults only occur on hits, that the 17 offset bits always pass through unchanged, that instruction-side results never carry the guarded attribute, and that misses carry no attribute or address. Several behaviours depend on what software has programmed, and only the bench's scenarios can show them: the masked index compare, the privilege-qualified validity, the lowest-entry priority when entries overlap, the side separation and the protection decoding.

// File: rtl/bat_pkg.sv
package bat_pkg;

    typedef enum logic [1:0] {
        PROT_NONE   = 2'b00,
        PROT_RO     = 2'b01,
        PROT_RW     = 2'b10,
        PROT_RO_ALT = 2'b11
    } prot_e;

    // Attribute nibble as held in the lower register, bits 6:3
    localparam int ATTR_LSB = 3;
    localparam int ATTR_W   = 4;
    localparam int PROT_W   = 2;

    function automatic logic prot_violation(input logic [PROT_W-1:0] code, input logic is_write);
        logic bad;
        case (prot_e'(code))
            PROT_NONE:   bad = 1'b1;
            PROT_RW:     bad = 1'b0;
            default:     bad = is_write;
        endcase
        return bad;
    endfunction

endpackage

// File: rtl/bat_entry_match.sv
module bat_entry_match #(
    parameter int ADDR_W  = 32,
    parameter int BLK_LSB = 17,
    parameter int BL_W    = 11
) (
    input  logic [ADDR_W-1:0]         ea,
    input  logic                      super_mode,
    input  logic [ADDR_W-BLK_LSB-1:0] eff_idx,
    input  logic [BL_W-1:0]           len_mask,
    input  logic                      sup_ok,
    input  logic                      usr_ok,
    input  logic [ADDR_W-BLK_LSB-1:0] phys_idx,
    output logic                      hit,
    output logic [ADDR_W-1:0]         pa
);
    localparam int IX_W = ADDR_W - BLK_LSB;

    logic [IX_W-1:0] care_n;
    logic [IX_W-1:0] ea_idx;
    logic            priv_ok;

    assign care_n  = {{(IX_W-BL_W){1'b0}}, len_mask};
    assign ea_idx  = ea[ADDR_W-1:BLK_LSB];
    assign priv_ok = super_mode ? sup_ok : usr_ok;

    always_comb begin
        hit = priv_ok && ((ea_idx & ~care_n) == (eff_idx & ~care_n));
        pa  = {phys_idx | (ea_idx & care_n), ea[BLK_LSB-1:0]};
    end
endmodule

// File: rtl/bat_prio_pick.sv
module bat_prio_pick #(
    parameter int N      = 4,
    parameter int ADDR_W = 32,
    parameter int ATTR_W = 4,
    parameter int PROT_W = 2
) (
    input  logic [N-1:0]             hit_i,
    input  logic [N-1:0][ADDR_W-1:0] pa_i,
    input  logic [N-1:0][ATTR_W-1:0] attr_i,
    input  logic [N-1:0][PROT_W-1:0] prot_i,
    output logic                     hit_o,
    output logic [ADDR_W-1:0]        pa_o,
    output logic [ATTR_W-1:0]        attr_o,
    output logic [PROT_W-1:0]        prot_o
);
    // Scan from the top down so the lowest matching index is assigned last
    always_comb begin
        hit_o  = 1'b0;
        pa_o   = '0;
        attr_o = '0;
        prot_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                hit_o  = 1'b1;
                pa_o   = pa_i[i];
                attr_o = attr_i[i];
                prot_o = prot_i[i];
            end
        end
    end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate #(
    parameter int NUM_PAIRS = 4,
    parameter int ADDR_W    = 32,
    parameter int BLK_LSB   = 17,
    parameter int BL_W      = 11,
    parameter int CA_W      = $clog2(NUM_PAIRS) + 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [CA_W-1:0]                cfg_addr,
    input  logic [ADDR_W-1:0]              cfg_wdata,
    output logic [ADDR_W-1:0]              cfg_rdata,
    input  logic                           lk_req,
    input  logic [ADDR_W-1:0]              lk_ea,
    input  logic                           lk_is_data,
    input  logic                           lk_super,
    input  logic                           lk_write,
    output logic                           rsp_vld,
    output logic                           rsp_hit,
    output logic [ADDR_W-1:0]              rsp_pa,
    output logic [bat_pkg::ATTR_W-1:0]     rsp_attr,
    output logic                           rsp_fault
);
    import bat_pkg::*;

    localparam int NSLOT   = 2 * NUM_PAIRS;
    localparam int SLOT_W  = CA_W - 1;
    localparam int IX_W    = ADDR_W - BLK_LSB;
    localparam int GRD_BIT = ATTR_LSB;
    localparam int UP_GAP  = BLK_LSB - BL_W - 2;
    localparam int LO_GAP  = BLK_LSB - (ATTR_LSB + ATTR_W);

    localparam logic [ADDR_W-1:0] UPPER_KEEP =
        {{IX_W{1'b1}}, {UP_GAP{1'b0}}, {BL_W{1'b1}}, 2'b11};
    localparam logic [ADDR_W-1:0] LOWER_KEEP_D =
        {{IX_W{1'b1}}, {LO_GAP{1'b0}}, {ATTR_W{1'b1}}, 1'b0, {PROT_W{1'b1}}};
    localparam logic [ADDR_W-1:0] LOWER_KEEP_I =
        LOWER_KEEP_D & ~(ADDR_W'(1) << GRD_BIT);

    typedef struct packed {
        logic [NSLOT-1:0][ADDR_W-1:0] upper;
        logic [NSLOT-1:0][ADDR_W-1:0] lower;
        logic                         vld;
        logic                         hit;
        logic [ADDR_W-1:0]            pa;
        logic [ATTR_W-1:0]            attr;
        logic                         fault;
    } state_t;

    state_t st_d, st_q;

    logic [SLOT_W-1:0] cfg_slot;
    logic              cfg_data_side;

    assign cfg_slot      = cfg_addr[CA_W-1:1];
    assign cfg_data_side = cfg_addr[CA_W-1];

    // Per-entry match results
    logic [NSLOT-1:0]             ent_hit;
    logic [NSLOT-1:0][ADDR_W-1:0] ent_pa;
    logic [NSLOT-1:0][ATTR_W-1:0] ent_attr;
    logic [NSLOT-1:0][PROT_W-1:0] ent_prot;

    for (genvar s = 0; s < NSLOT; s++) begin : g_ent
        bat_entry_match #(
            .ADDR_W (ADDR_W),
            .BLK_LSB(BLK_LSB),
            .BL_W   (BL_W)
        ) u_match (
            .ea        (lk_ea),
            .super_mode(lk_super),
            .eff_idx   (st_q.upper[s][ADDR_W-1:BLK_LSB]),
            .len_mask  (st_q.upper[s][BL_W+1:2]),
            .sup_ok    (st_q.upper[s][1]),
            .usr_ok    (st_q.upper[s][0]),
            .phys_idx  (st_q.lower[s][ADDR_W-1:BLK_LSB]),
            .hit       (ent_hit[s]),
            .pa        (ent_pa[s])
        );
        assign ent_attr[s] = st_q.lower[s][ATTR_LSB+ATTR_W-1:ATTR_LSB];
        assign ent_prot[s] = st_q.lower[s][PROT_W-1:0];
    end

    // One priority picker per side: index 0 instruction, 1 data
    logic [1:0]             side_hit;
    logic [1:0][ADDR_W-1:0] side_pa;
    logic [1:0][ATTR_W-1:0] side_attr;
    logic [1:0][PROT_W-1:0] side_prot;

    for (genvar d = 0; d < 2; d++) begin : g_side
        bat_prio_pick #(
            .N     (NUM_PAIRS),
            .ADDR_W(ADDR_W),
            .ATTR_W(ATTR_W),
            .PROT_W(PROT_W)
        ) u_pick (
            .hit_i (ent_hit [d*NUM_PAIRS +: NUM_PAIRS]),
            .pa_i  (ent_pa  [d*NUM_PAIRS +: NUM_PAIRS]),
            .attr_i(ent_attr[d*NUM_PAIRS +: NUM_PAIRS]),
            .prot_i(ent_prot[d*NUM_PAIRS +: NUM_PAIRS]),
            .hit_o (side_hit[d]),
            .pa_o  (side_pa[d]),
            .attr_o(side_attr[d]),
            .prot_o(side_prot[d])
        );
    end

    logic              sel_hit;
    logic [ADDR_W-1:0] sel_pa;
    logic [ATTR_W-1:0] sel_attr;
    logic [PROT_W-1:0] sel_prot;

    always_comb begin
        sel_hit  = side_hit [lk_is_data];
        sel_pa   = side_pa  [lk_is_data];
        sel_attr = side_attr[lk_is_data];
        sel_prot = side_prot[lk_is_data];
    end

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            if (cfg_addr[0]) begin
                st_d.lower[cfg_slot] = cfg_wdata &
                    (cfg_data_side ? LOWER_KEEP_D : LOWER_KEEP_I);
            end else begin
                st_d.upper[cfg_slot] = cfg_wdata & UPPER_KEEP;
            end
        end
        st_d.vld   = lk_req;
        st_d.hit   = lk_req && sel_hit;
        st_d.pa    = (lk_req && sel_hit) ? sel_pa   : '0;
        st_d.attr  = (lk_req && sel_hit) ? sel_attr : '0;
        st_d.fault = lk_req && sel_hit && prot_violation(sel_prot, lk_write);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rdata = cfg_addr[0] ? st_q.lower[cfg_slot] : st_q.upper[cfg_slot];
    assign rsp_vld   = st_q.vld;
    assign rsp_hit   = st_q.hit;
    assign rsp_pa    = st_q.pa;
    assign rsp_attr  = st_q.attr;
    assign rsp_fault = st_q.fault;
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk #(
    parameter int ADDR_W  = 32,
    parameter int BLK_LSB = 17,
    parameter int ATTR_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_req,
    input logic [ADDR_W-1:0] lk_ea,
    input logic              lk_is_data,
    input logic              rsp_vld,
    input logic              rsp_hit,
    input logic [ADDR_W-1:0] rsp_pa,
    input logic [ATTR_W-1:0] rsp_attr,
    input logic              rsp_fault
);
    p_req_gives_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_vld);

    p_no_req_no_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_vld);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_vld |-> (!rsp_hit && !rsp_fault && rsp_pa == '0 && rsp_attr == '0));

    p_fault_on_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_hit);

    p_offset_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (!rsp_hit || rsp_pa[BLK_LSB-1:0] == $past(lk_ea[BLK_LSB-1:0])));

    p_instr_unguarded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !lk_is_data) |=> !rsp_attr[0]);

    p_miss_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !rsp_hit) |-> (rsp_attr == '0 && rsp_pa == '0));
endmodule

bind bat_xlate bat_xlate_chk #(
    .ADDR_W (ADDR_W),
    .BLK_LSB(BLK_LSB),
    .ATTR_W (bat_pkg::ATTR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .lk_ea     (lk_ea),
    .lk_is_data(lk_is_data),
    .rsp_vld   (rsp_vld),
    .rsp_hit   (rsp_hit),
    .rsp_pa    (rsp_pa),
    .rsp_attr  (rsp_attr),
    .rsp_fault (rsp_fault)
);

// File: tb/bat_xlate_tb.sv
module bat_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lk_req = 1'b0;
    logic [31:0] lk_ea = '0;
    logic        lk_is_data = 1'b0;
    logic        lk_super = 1'b0;
    logic        lk_write = 1'b0;
    logic        rsp_vld, rsp_hit, rsp_fault;
    logic [31:0] rsp_pa;
    logic [3:0]  rsp_attr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bat_xlate u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lk_req(lk_req), .lk_ea(lk_ea), .lk_is_data(lk_is_data), .lk_super(lk_super),
        .lk_write(lk_write),
        .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa), .rsp_attr(rsp_attr),
        .rsp_fault(rsp_fault)
    );

    typedef struct packed {
        logic        dside;
        logic        sup;
        logic        wr;
        logic [31:0] ea;
        logic        hit;
        logic [31:0] pa;
        logic [3:0]  attr;
        logic        flt;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VT [NV] = '{
        '{1'b1, 1'b1, 1'b0, 32'h1000_0100, 1'b1, 32'h8000_0100, 4'b1001, 1'b0, 8'd8},  // R8 overlap D0 wins
        '{1'b1, 1'b1, 1'b0, 32'h1004_0000, 1'b1, 32'h9004_0000, 4'b0100, 1'b0, 8'd5},  // R5 1 MB block
        '{1'b1, 1'b1, 1'b1, 32'h1004_0000, 1'b1, 32'h9004_0000, 4'b0100, 1'b1, 8'd10}, // R10 write to RO
        '{1'b1, 1'b0, 1'b0, 32'h1004_0000, 1'b0, 32'h0,         4'b0000, 1'b0, 8'd4},  // R4 user, sup-only
        '{1'b1, 1'b0, 1'b0, 32'h2ABC_1234, 1'b1, 32'h4ABC_1234, 4'b0010, 1'b1, 8'd6},  // R6 256 MB, no access
        '{1'b1, 1'b1, 1'b0, 32'h2ABC_1234, 1'b0, 32'h0,         4'b0000, 1'b0, 8'd4},  // R4 sup, user-only
        '{1'b1, 1'b1, 1'b0, 32'h3000_5678, 1'b1, 32'h3000_5678, 4'b0000, 1'b0, 8'd10}, // R10 code 11 read
        '{1'b1, 1'b0, 1'b1, 32'h3000_5678, 1'b1, 32'h3000_5678, 4'b0000, 1'b1, 8'd10}, // R10 code 11 write
        '{1'b0, 1'b1, 1'b0, 32'h1000_0010, 1'b1, 32'h5000_0010, 4'b1000, 1'b0, 8'd7},  // R7 instr side
        '{1'b0, 1'b0, 1'b1, 32'h1000_0010, 1'b1, 32'h5000_0010, 4'b1000, 1'b0, 8'd10}, // R10 code 10 write
        '{1'b0, 1'b1, 1'b0, 32'h1004_0000, 1'b0, 32'h0,         4'b0000, 1'b0, 8'd7},  // R7 data entry unseen
        '{1'b1, 1'b1, 1'b0, 32'h7000_0000, 1'b0, 32'h0,         4'b0000, 1'b0, 8'd9},  // R9 miss clean
        '{1'b1, 1'b1, 1'b0, 32'h1002_0000, 1'b1, 32'h9002_0000, 4'b0100, 1'b0, 8'd5},  // R5 bit 17 masked
        '{1'b1, 1'b1, 1'b1, 32'h1000_0100, 1'b1, 32'h8000_0100, 4'b1001, 1'b0, 8'd10}, // R10 RW write
        '{1'b1, 1'b0, 1'b0, 32'h1000_0100, 1'b1, 32'h8000_0100, 4'b1001, 1'b0, 8'd4}   // R4 user valid
    };

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd_check(input string rq, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(rq, cfg_rdata, exp);
    endtask

    task automatic lookup(input logic d, input logic s, input logic w, input logic [31:0] ea);
        @(negedge clk);
        lk_req = 1'b1; lk_is_data = d; lk_super = s; lk_write = w; lk_ea = ea;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every register zero after reset, nothing hits
        for (int a = 0; a < 16; a++) cfg_rd_check("R1", 4'(a), 32'h0);
        lookup(1'b1, 1'b1, 1'b0, 32'h0000_0000);
        check("R1 vld", {31'b0, rsp_vld}, 32'h1);
        check("R1 hit", {31'b0, rsp_hit}, 32'h0);
        lookup(1'b0, 1'b0, 1'b0, 32'h0000_0000);
        check("R1 hit", {31'b0, rsp_hit}, 32'h0);

        // R2: unused bits read zero
        cfg_wr(4'd6, 32'hFFFF_FFFF);
        cfg_rd_check("R2 upper", 4'd6, 32'hFFFE_1FFF);
        cfg_wr(4'd15, 32'hFFFF_FFFF);
        cfg_rd_check("R2 lower", 4'd15, 32'hFFFE_007B);
        cfg_wr(4'd6, 32'h0);
        cfg_rd_check("R2 clear", 4'd6, 32'h0);

        // Program entries: D0..D3 at 8..15, I0 at 0/1
        cfg_wr(4'd8,  32'h1000_0003); cfg_wr(4'd9,  32'h8000_004A);
        cfg_wr(4'd10, 32'h1000_001E); cfg_wr(4'd11, 32'h9000_0021);
        cfg_wr(4'd12, 32'h2000_1FFD); cfg_wr(4'd13, 32'h4000_0010);
        cfg_wr(4'd14, 32'h3000_0003); cfg_wr(4'd15, 32'h3000_0003);
        cfg_wr(4'd0,  32'h1000_0003); cfg_wr(4'd1,  32'h5000_004A);

        // R3: guarded bit dropped on instruction side only
        cfg_rd_check("R3 instr", 4'd1, 32'h5000_0042);
        cfg_rd_check("R3 data",  4'd9, 32'h8000_004A);
        cfg_rd_check("R2 upper", 4'd10, 32'h1000_001E);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VT[i].rq, i);
            lookup(VT[i].dside, VT[i].sup, VT[i].wr, VT[i].ea);
            check({tag, " vld"},   {31'b0, rsp_vld},   32'h1);
            check({tag, " hit"},   {31'b0, rsp_hit},   {31'b0, VT[i].hit});
            check({tag, " pa"},    rsp_pa,             VT[i].pa);
            check({tag, " attr"},  {28'b0, rsp_attr},  {28'b0, VT[i].attr});
            check({tag, " fault"}, {31'b0, rsp_fault}, {31'b0, VT[i].flt});
        end

        // R11: one idle cycle later the response is cleared
        @(negedge clk);
        check("R11 idle vld", {31'b0, rsp_vld}, 32'h0);
        check("R11 idle pa", rsp_pa, 32'h0);

        // R8: invalidate D0, the overlapping D1 now answers
        cfg_wr(4'd8, 32'h0);
        lookup(1'b1, 1'b1, 1'b0, 32'h1000_0100);
        check("R8 next entry", rsp_pa, 32'h9000_0100);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule